// File: doc/BRIEF.md
# Debug Execution Cycle Counter

This block is the measurement counter inside an in-circuit debug unit. While the target CPU runs, it counts one of two selectable sources: a one-microsecond tick, which measures elapsed time, or a strobe that marks each executed bus cycle. While the CPU is halted, the count does not change. The host reads the count and a sticky overflow flag.

A small configuration register holds two bits. One bit picks the count source. The other picks how runs are combined. In accumulate mode, the counts from successive runs add together. In per-run mode, every run-start pulse clears the counter, so the value covers only the latest run. For single-stepping in per-run mode, the debugger issues one run-start pulse per step request. A one-step request therefore clears the counter before every step.

The counter is cleared by any of three events:
- a configuration write that changes either mode bit;
- a CPU reset pulse;
- a run start while per-run mode is selected.

A control state machine has three states:
- `ST_HALTED`: the CPU is not running and the count is not saturated.
- `ST_COUNTING`: the CPU is running.
- `ST_SATURATED`: the count is pinned at its maximum.

The transitions are:
- `HALTED→COUNTING` when the running flag rises.
- `COUNTING→HALTED` when the running flag falls.
- `HALTED→SATURATED` or `COUNTING→SATURATED` when an increment is attempted at the maximum value.
- From any state, a clear event moves to `COUNTING` or `HALTED`, according to the running flag.

The overflow flag is high exactly while the state is `ST_SATURATED`.

Top module: `exec_cycle_counter`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the source is bus cycles (`cfg_src_time`=0) and accumulate mode is selected (`cfg_clear_per_run`=0).
- R2: With `cpu_running`=1, the count rises by exactly 1 on each cycle in which the selected source is high. That source is `us_tick` when the stored source bit is 1 and `bus_strobe` when it is 0. The other source has no effect.
- R3: While `cpu_running`=0, the count does not change unless a clear event occurs.
- R4: In accumulate mode, `run_start` does not clear the count, and counts from successive runs add together.
- R5: In per-run mode, the clock edge that samples `run_start`=1 sets the count to 0.
- R6: A `cfg_we` write that changes either stored mode bit clears the count and the overflow flag. A write with identical values clears nothing.
- R7: A `cpu_reset` pulse clears the count and the overflow flag in either mode.
- R8: An increment attempted at the maximum value 2^CNT_W-1 leaves the count at all ones and sets the overflow flag. The flag stays set until a clear event.
- R9: When a clear event and an increment fall in the same cycle, the count ends at 0 and the overflow flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| bus_strobe | input | 1 | One-cycle pulse per executed bus cycle |
| cpu_running | input | 1 | High while the target CPU executes |
| run_start | input | 1 | Pulse at the start of each run or step request |
| cpu_reset | input | 1 | Pulse when the target CPU is reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_src_time | input | 1 | Written source bit: 1 = time, 0 = bus cycles |
| cfg_clear_per_run | input | 1 | Written mode bit: 1 = per-run clear, 0 = accumulate |
| count_value | output | CNT_W | Current count |
| count_overflow | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with CNT_W=4, so the maximum is 15. This puts saturation, the sticky overflow flag and clear-versus-increment collisions at the maximum within a handful of cycles. Directed phases cover each mode and clear event. A long pseudo-random phase then mixes mode writes, resets, run starts and both sources. A behavioural model tracks every cycle, and the bench compares the count and flag against it after each clock.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [1:0] {
        ST_HALTED    = 2'd0,
        ST_COUNTING  = 2'd1,
        ST_SATURATED = 2'd2
    } ecc_state_e;

    typedef enum logic {
        SRC_BUS  = 1'b0,
        SRC_TIME = 1'b1
    } ecc_src_e;

endpackage

// File: rtl/ecc_mode_reg.sv
module ecc_mode_reg
    import ecc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     wr_src_time,
    input  logic     wr_per_run,
    output ecc_src_e src_q,
    output logic     per_run_q,
    output logic     mode_change
);

    always_comb begin
        mode_change = wr_en && ((wr_src_time != src_q) || (wr_per_run != per_run_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= SRC_BUS;
            per_run_q <= 1'b0;
        end else if (wr_en) begin
            src_q     <= ecc_src_e'(wr_src_time);
            per_run_q <= wr_per_run;
        end
    end

endmodule

// File: rtl/ecc_event_sel.sv
module ecc_event_sel
    import ecc_pkg::*;
(
    input  ecc_src_e src_sel,
    input  logic     us_tick,
    input  logic     bus_strobe,
    input  logic     cpu_running,
    output logic     count_evt
);

    always_comb begin
        unique case (src_sel)
            SRC_TIME: count_evt = cpu_running && us_tick;
            SRC_BUS:  count_evt = cpu_running && bus_strobe;
            default:  count_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/ecc_count_fsm.sv
module ecc_count_fsm
    import ecc_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_evt,
    input  logic             count_evt,
    input  logic             cpu_running,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ecc_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_d;
    logic             at_max;
    logic             inc_ok;

    assign at_max = (count_q == CNT_MAX);
    assign inc_ok = count_evt && (state_q != ST_SATURATED);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (clr_evt) begin
            state_d = cpu_running ? ST_COUNTING : ST_HALTED;
        end else begin
            unique case (state_q)
                ST_HALTED: begin
                    if (inc_ok && at_max)  state_d = ST_SATURATED;
                    else if (cpu_running)  state_d = ST_COUNTING;
                end
                ST_COUNTING: begin
                    if (inc_ok && at_max)  state_d = ST_SATURATED;
                    else if (!cpu_running) state_d = ST_HALTED;
                end
                ST_SATURATED: state_d = ST_SATURATED;
                default:      state_d = ST_HALTED;
            endcase
        end
    end

    // count datapath
    always_comb begin
        count_d = count_q;
        if (clr_evt) begin
            count_d = '0;
        end else if (inc_ok && !at_max) begin
            count_d = count_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // outputs
    always_comb begin
        ovf = (state_q == ST_SATURATED);
    end

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_running && !clr_evt) |=> $stable(count_q)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_evt && !clr_evt && !ovf && !at_max) |=> (count_q == $past(count_q) + CNT_ONE)); // R2
    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_evt) |=> (ovf && count_q == CNT_MAX)); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (count_q == '0 && !ovf)); // R9
    AST_OVF_ONLY_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (count_q == CNT_MAX)); // R8

endmodule

// File: rtl/exec_cycle_counter.sv
module exec_cycle_counter
    import ecc_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             bus_strobe,
    input  logic             cpu_running,
    input  logic             run_start,
    input  logic             cpu_reset,
    input  logic             cfg_we,
    input  logic             cfg_src_time,
    input  logic             cfg_clear_per_run,
    output logic [CNT_W-1:0] count_value,
    output logic             count_overflow
);

    ecc_src_e src_q;
    logic     per_run_q;
    logic     mode_change;
    logic     count_evt;
    logic     clr_evt;

    ecc_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_src_time (cfg_src_time),
        .wr_per_run  (cfg_clear_per_run),
        .src_q       (src_q),
        .per_run_q   (per_run_q),
        .mode_change (mode_change)
    );

    ecc_event_sel u_evt (
        .src_sel     (src_q),
        .us_tick     (us_tick),
        .bus_strobe  (bus_strobe),
        .cpu_running (cpu_running),
        .count_evt   (count_evt)
    );

    assign clr_evt = cpu_reset || mode_change || (run_start && per_run_q);

    ecc_count_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_evt     (clr_evt),
        .count_evt   (count_evt),
        .cpu_running (cpu_running),
        .count_q     (count_value),
        .ovf         (count_overflow)
    );

    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_src_time != src_q)) |=> (count_value == '0 && !count_overflow)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset |=> (count_value == '0 && !count_overflow)); // R7
    AST_PERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && per_run_q) |=> (count_value == '0)); // R5
    AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && !per_run_q && !cpu_reset && !cfg_we && !cpu_running) |=> $stable(count_value)); // R4

endmodule

// File: tb/exec_cycle_counter_tb.sv
module exec_cycle_counter_tb;

    localparam int W   = 4;
    localparam int MAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, bus_strobe = 1'b0, cpu_running = 1'b0;
    logic run_start = 1'b0, cpu_reset = 1'b0, cfg_we = 1'b0;
    logic cfg_src_time = 1'b0, cfg_clear_per_run = 1'b0;
    logic [W-1:0] count_value;
    logic count_overflow;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    int m_cnt = 0;
    bit m_ovf = 0, m_src = 0, m_per = 0;

    always #2.5 clk = ~clk;

    exec_cycle_counter #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_strobe(bus_strobe),
        .cpu_running(cpu_running), .run_start(run_start), .cpu_reset(cpu_reset),
        .cfg_we(cfg_we), .cfg_src_time(cfg_src_time), .cfg_clear_per_run(cfg_clear_per_run),
        .count_value(count_value), .count_overflow(count_overflow)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_src = 0; m_per = 0;
        end else begin
            bit clr, evt;
            clr = cpu_reset || (cfg_we && (cfg_src_time != m_src || cfg_clear_per_run != m_per))
                  || (run_start && m_per);
            evt = cpu_running && (m_src ? us_tick : bus_strobe);
            if (cfg_we) begin
                m_src = cfg_src_time;
                m_per = cfg_clear_per_run;
            end
            if (clr) begin
                m_cnt = 0; m_ovf = 0;
            end else if (evt && !m_ovf) begin
                if (m_cnt == MAX) m_ovf = 1;
                else m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check(cur_req, int'(count_value), m_cnt, "count vs model");
        check(cur_req, int'(count_overflow), int'(m_ovf), "overflow vs model");
    endtask

    task automatic pulse_src(bit bus, bit tick, int n);
        for (int i = 0; i < n; i++) begin
            bus_strobe = bus; us_tick = tick;
            cyc();
            bus_strobe = 0; us_tick = 0;
            cyc();
        end
    endtask

    task automatic write_cfg(bit src, bit per);
        cfg_we = 1; cfg_src_time = src; cfg_clear_per_run = per;
        cyc();
        cfg_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R1: reset state
        check("R1", int'(count_value), 0, "count after reset");
        check("R1", int'(count_overflow), 0, "overflow after reset");

        // R2: bus source counts, tick ignored
        cur_req = "R2";
        cpu_running = 1;
        pulse_src(1, 0, 5);
        check("R2", int'(count_value), 5, "five bus strobes");
        pulse_src(0, 1, 3);
        check("R2", int'(count_value), 5, "ticks ignored in bus mode");

        // R3: halted
        cur_req = "R3";
        cpu_running = 0;
        pulse_src(1, 1, 4);
        check("R3", int'(count_value), 5, "no count while halted");

        // R4: accumulate across runs
        cur_req = "R4";
        run_start = 1; cyc(); run_start = 0;
        check("R4", int'(count_value), 5, "run_start ignored in accumulate");
        cpu_running = 1;
        pulse_src(1, 0, 2);
        check("R4", int'(count_value), 7, "second run adds");

        // R6: same write keeps, source change clears
        cur_req = "R6";
        write_cfg(0, 0);
        cyc();
        check("R6", int'(count_value), 7, "identical write keeps count");
        write_cfg(1, 0);
        check("R6", int'(count_value), 0, "source change clears");
        cur_req = "R2";
        pulse_src(0, 1, 3);
        pulse_src(1, 0, 2);
        check("R2", int'(count_value), 3, "time source counts ticks only");

        // R6/R5
        cur_req = "R6";
        write_cfg(1, 1);
        check("R6", int'(count_value), 0, "per-run bit change clears");
        cur_req = "R5";
        pulse_src(0, 1, 4);
        run_start = 1; cyc(); run_start = 0;
        check("R5", int'(count_value), 0, "run_start clears in per-run");
        pulse_src(0, 1, 1);
        run_start = 1; cyc(); run_start = 0;
        check("R5", int'(count_value), 0, "single-step clears each step");

        // R7
        cur_req = "R7";
        pulse_src(0, 1, 6);
        cpu_reset = 1; cyc(); cpu_reset = 0;
        check("R7", int'(count_value), 0, "cpu reset clears per-run");
        write_cfg(0, 0);
        pulse_src(1, 0, 3);
        cpu_reset = 1; cyc(); cpu_reset = 0;
        check("R7", int'(count_value), 0, "cpu reset clears accumulate");

        // R8
        cur_req = "R8";
        pulse_src(1, 0, MAX);
        check("R8", int'(count_value), MAX, "reached max");
        check("R8", int'(count_overflow), 0, "no flag at max");
        pulse_src(1, 0, 3);
        check("R8", int'(count_value), MAX, "saturated");
        check("R8", int'(count_overflow), 1, "flag set");
        cpu_running = 0; run_start = 1; cyc(); run_start = 0;
        check("R8", int'(count_overflow), 1, "flag sticky");

        // R9: clear with simultaneous increment
        cur_req = "R9";
        cpu_running = 1; bus_strobe = 1; cpu_reset = 1; cyc();
        bus_strobe = 0; cpu_reset = 0;
        check("R9", int'(count_value), 0, "clear beats increment");
        check("R9", int'(count_overflow), 0, "clear drops flag");
        pulse_src(1, 0, MAX);
        bus_strobe = 1; cfg_we = 1; cfg_src_time = 0; cfg_clear_per_run = 1; cyc();
        bus_strobe = 0; cfg_we = 0;
        check("R9", int'(count_value), 0, "mode write beats increment at max");

        // mixed pseudo-random phase
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            cpu_running  = ($urandom_range(0, 9) != 0);
            bus_strobe   = $urandom_range(0, 1) != 0;
            us_tick      = $urandom_range(0, 2) == 0;
            run_start    = (r < 3);
            cpu_reset    = (r == 50);
            cfg_we       = (r > 96);
            cfg_src_time = $urandom_range(0, 1) != 0;
            cfg_clear_per_run = $urandom_range(0, 1) != 0;
            cyc();
        end
        run_start = 0; cpu_reset = 0; cfg_we = 0;
        cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule